// File: doc/BRIEF.md
# E1 Multiframe Overhead Rewriter

This block sits on a byte-wide E1 PCM path just before the line side. It receives one 8-bit timeslot per valid cycle, together with a strobe on timeslot 0 of every frame and a second strobe on timeslot 0 of frame 0 of each 16-frame CRC-4 multiframe. It rewrites the overhead bits of timeslot 0 and, when the alarm fill is on, the payload timeslots. Each rewritten byte leaves one clock after it arrives.

A host loads one 8-bit control word. The write goes into a shadow register. The shadow is copied into the active configuration only on the next multiframe-start byte, so a multiframe never mixes two settings. The block keeps two CRC check results from the receive side and uses them for the E-bits when automatic E-bit mode is selected.

Bit numbering: bit 7 of a byte is transmitted first. The overhead positions are:
- C-bits: bit 7 of timeslot 0 in even frames.
- A-bit: bit 5 of timeslot 0 in odd frames.
- E-bits: bit 7 of timeslot 0 in frames 13 and 15.

Top module: `e1_ovr_rewriter`

## Requirements
- R1: `outValid` equals `inValid` delayed by one clock, and `outData` carries the rewritten byte in that cycle. While `outValid` is low, `outData` holds its last value. Both outputs are 0 after reset.
- R2: Control bit 0 is the global enable. While the active enable is 0, every output byte equals its input byte exactly.
- R3: A control write is stored in a shadow register. The shadow becomes active starting with the byte that has `inValid` and `inMfStart` both high. A write made in the same cycle as that byte takes effect only one multiframe later. Reset loads 0 into both the shadow and the active configuration.
- R4: Control bits 2:1 select the CRC field. With 00 or the illegal value 11, the C-bits pass unchanged. With 01, every C-bit is sent as 1.
- R5: With CRC field 10, the C-bits carry a recomputed CRC-4 (polynomial x^4+x+1, initial value 0):
  - The CRC covers all bytes of each 8-frame submultiframe, serially with bit 7 first, with the C-bit positions read as 0.
  - The result of one submultiframe goes into the C-bits of the next, MSB in frame 0 (or 8) through LSB in frame 6 (or 14).
  - Before the first result is complete, the C-bits are sent as 0.
- R6: Control bit 4 selects the A-bit source. With 0 the A-bit passes unchanged. With 1 it is replaced by control bit 7, the buffer bit.
- R7: Control bit 5 enables automatic E-bits. Each pulse of `crcResValid` shifts in `crcResOk` (1 = OK, 0 = error).
  - The older of the last two results is sent in frame 13, the newer in frame 15.
  - An error result is sent as 0 and an OK result as 1.
  - Both stored results reset to OK.
- R8: Control bit 6 enables the alarm fill. When it is on, every timeslot other than 0 is sent as 0xFF. Timeslot 0 still carries its framing and overhead, rewritten according to the other fields.
- R9: Reserved control bit 3 has no effect on the output.
- R10: Timeslot and frame positions come only from the strobes. Idle cycles with `inValid` low may fall anywhere and do not shift positions. All rewriting applies only when the active enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 8 | Incoming timeslot byte |
| inValid | input | 1 | `inData` is valid this cycle |
| inFrameStart | input | 1 | Byte is timeslot 0 of a frame |
| inMfStart | input | 1 | Byte is timeslot 0 of frame 0 of a multiframe |
| cfgWe | input | 1 | Host control write strobe |
| cfgData | input | 8 | Host control word |
| crcResValid | input | 1 | A CRC check result is present |
| crcResOk | input | 1 | CRC check result: 1 = OK, 0 = error |
| outData | output | 8 | Rewritten byte |
| outValid | output | 1 | `outData` is valid |

## Verification
The assertions check these behaviours on every cycle:
- the one-cycle valid latency;
- exact pass-through while disabled;
- the 0xFF fill of payload timeslots;
- forced-one C-bits;
- the A-bit and E-bit substitutions;
- that the active configuration never changes away from a multiframe start.

Only the bench scenarios can show the rest, by comparing every byte against an independent model:
- the recomputed CRC-4 values and the submultiframe in which they appear;
- that a write made mid-multiframe or on the boundary byte takes effect exactly one multiframe later;
- that the reserved bit is ignored;
- that idle gaps do not disturb position tracking.

// File: rtl/e1ovr_pkg.sv
package e1ovr_pkg;
  localparam int TS_PER_FRAME = 32;
  localparam int FRM_PER_MF   = 16;
  localparam int FRM_PER_SMF  = 8;
  localparam int TS_W   = $clog2(TS_PER_FRAME);
  localparam int FRM_W  = $clog2(FRM_PER_MF);
  localparam int SMF_W  = $clog2(FRM_PER_SMF);
  localparam int CRC_W  = 4;
  localparam int E_FRM_A = 13;
  localparam int E_FRM_B = 15;
  localparam int C_BIT = 7;
  localparam int A_BIT = 5;
  localparam int E_BIT = 7;

  typedef enum logic [1:0] {
    CRC_PASS  = 2'b00,
    CRC_ONES  = 2'b01,
    CRC_CALC  = 2'b10,
    CRC_BAD   = 2'b11
  } crc_sel_e;

  typedef struct packed {
    logic     bufBit;
    logic     ais;
    logic     eAuto;
    logic     aFromBuf;
    logic     rsvd;
    crc_sel_e crcMode;
    logic     en;
  } cfg_t;

  typedef struct packed {
    logic       en;
    logic       ais;
    crc_sel_e   crcMode;
    logic       aFromBuf;
    logic       aVal;
    logic       eAuto;
    logic       eVal;
    logic       payload;
    logic       cSlot;
    logic       aSlot;
    logic       eSlot;
    logic       smfFirst;
    logic       smfLast;
    logic [1:0] cIdx;
  } ovr_strobe_t;

  function automatic logic [CRC_W-1:0] crc4Byte(input logic [CRC_W-1:0] seed,
                                               input logic [7:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = seed;
    for (int i = 7; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ din[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    return c;
  endfunction
endpackage

// File: rtl/e1ovr_ctrl.sv
module e1ovr_ctrl
  import e1ovr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inFrameStart,
  input  logic        inMfStart,
  input  logic        cfgWe,
  input  logic [7:0]  cfgData,
  input  logic        crcResValid,
  input  logic        crcResOk,
  output ovr_strobe_t strb
);
  logic [TS_W-1:0]  tsReg, curTs;
  logic [FRM_W-1:0] frmReg, curFrm;
  cfg_t shadowCfg, activeCfg, effCfg;
  logic [1:0] eHist;
  logic mfHit, tsZero;

  assign mfHit  = inValid && inMfStart;
  assign curTs  = (inMfStart || inFrameStart) ? '0 : tsReg + 1'b1;
  assign curFrm = inMfStart ? '0 : (inFrameStart ? frmReg + 1'b1 : frmReg);
  assign effCfg = mfHit ? shadowCfg : activeCfg;
  assign tsZero = (curTs == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsReg     <= '0;
      frmReg    <= '0;
      shadowCfg <= '0;
      activeCfg <= '0;
      eHist     <= 2'b11;
    end else begin
      if (inValid) begin
        tsReg  <= curTs;
        frmReg <= curFrm;
      end
      if (mfHit) activeCfg <= shadowCfg;
      if (cfgWe) shadowCfg <= cfgData;
      if (crcResValid) eHist <= {eHist[0], crcResOk};
    end
  end

  always_comb begin
    strb          = '0;
    strb.en       = effCfg.en;
    strb.ais      = effCfg.ais;
    strb.crcMode  = effCfg.crcMode;
    strb.aFromBuf = effCfg.aFromBuf;
    strb.aVal     = effCfg.bufBit;
    strb.eAuto    = effCfg.eAuto;
    strb.eVal     = (curFrm == FRM_W'(E_FRM_A)) ? eHist[1] : eHist[0];
    strb.payload  = !tsZero;
    strb.cSlot    = tsZero && !curFrm[0];
    strb.aSlot    = tsZero && curFrm[0];
    strb.eSlot    = tsZero && (curFrm == FRM_W'(E_FRM_A) || curFrm == FRM_W'(E_FRM_B));
    strb.smfFirst = tsZero && (curFrm[SMF_W-1:0] == '0);
    strb.smfLast  = (curTs == TS_W'(TS_PER_FRAME-1)) && (curFrm[SMF_W-1:0] == SMF_W'(FRM_PER_SMF-1));
    strb.cIdx     = curFrm[SMF_W-1:1];
  end

  // R3: the active configuration only moves on a multiframe-start byte
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !mfHit |=> $stable(activeCfg));
endmodule

// File: rtl/e1ovr_datapath.sv
module e1ovr_datapath
  import e1ovr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  ovr_strobe_t strb,
  output logic [7:0]  outData,
  output logic        outValid
);
  logic [7:0] stage1, crcView, nextByte;
  logic [CRC_W-1:0] crcAcc, crcHold, crcNext;

  always_comb begin
    stage1 = inData;
    if (strb.en) begin
      if (strb.payload && strb.ais) stage1 = 8'hFF;
      if (strb.aSlot && strb.aFromBuf) stage1[A_BIT] = strb.aVal;
      if (strb.eSlot && strb.eAuto) stage1[E_BIT] = strb.eVal;
    end
    crcView = stage1;
    if (strb.cSlot) crcView[C_BIT] = 1'b0;
    nextByte = stage1;
    if (strb.en && strb.cSlot) begin
      unique case (strb.crcMode)
        CRC_ONES: nextByte[C_BIT] = 1'b1;
        CRC_CALC: nextByte[C_BIT] = crcHold[2'd3 - strb.cIdx];
        default:  nextByte[C_BIT] = stage1[C_BIT];
      endcase
    end
  end

  assign crcNext = crc4Byte(strb.smfFirst ? '0 : crcAcc, crcView);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc   <= '0;
      crcHold  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outData <= nextByte;
        crcAcc  <= crcNext;
        if (strb.smfLast) crcHold <= crcNext;
      end
    end
  end

  // R1: valid follows input with one cycle latency
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2: disabled means byte-exact pass-through
  a_r2_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !strb.en) |=> outData == $past(inData));
  // R4: forced-one C-bits
  a_r4_c_ones: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.en && strb.cSlot && strb.crcMode == CRC_ONES) |=> outData[C_BIT]);
  // R6: A-bit from buffer
  a_r6_abit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.en && strb.aSlot && strb.aFromBuf) |=> outData[A_BIT] == $past(strb.aVal));
  // R7: E-bit driven from stored CRC result
  a_r7_ebit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.en && strb.eSlot && strb.eAuto) |=> outData[E_BIT] == $past(strb.eVal));
  // R8: alarm fill of payload timeslots
  a_r8_ais_fill: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && strb.en && strb.ais && strb.payload) |=> outData == 8'hFF);
endmodule

// File: rtl/e1_ovr_rewriter.sv
module e1_ovr_rewriter
  import e1ovr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inFrameStart,
  input  logic       inMfStart,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  input  logic       crcResValid,
  input  logic       crcResOk,
  output logic [7:0] outData,
  output logic       outValid
);
  ovr_strobe_t strb;

  e1ovr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFrameStart(inFrameStart),
    .inMfStart(inMfStart), .cfgWe(cfgWe), .cfgData(cfgData),
    .crcResValid(crcResValid), .crcResOk(crcResOk), .strb(strb)
  );

  e1ovr_datapath u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .strb(strb),
    .outData(outData), .outValid(outValid)
  );
endmodule

// File: tb/e1_ovr_rewriter_tb.sv
module e1_ovr_rewriter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inFrameStart = 1'b0, inMfStart = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgData = '0;
  logic crcResValid = 1'b0, crcResOk = 1'b0;
  logic [7:0] outData;
  logic outValid;

  int checks = 0;
  int errors = 0;
  bit mfBad;
  string curTag;

  logic [7:0] mShadow = '0, mActive = '0;
  logic [1:0] mE = 2'b11;
  logic [3:0] mAcc = '0, mHold = '0;
  logic [15:0] lfsr = 16'hACE1;

  // Table of configurations: en=bit0, crc=bits2:1, rsvd=bit3, aBuf=bit4, eAuto=bit5, ais=bit6, bufBit=bit7
  localparam int N_CFG = 10;
  localparam logic [7:0] CFG_TAB [N_CFG] = '{
    8'h00, 8'h03, 8'h05, 8'h07, 8'h01, 8'h91, 8'h11, 8'h21, 8'h41, 8'h4D
  };

  always #5 clk = ~clk;

  e1_ovr_rewriter u_dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inFrameStart(inFrameStart), .inMfStart(inMfStart), .cfgWe(cfgWe),
    .cfgData(cfgData), .crcResValid(crcResValid), .crcResOk(crcResOk),
    .outData(outData), .outValid(outValid)
  );

  function automatic string tagOf(int i);
    case (i)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R4";
      4: return "R4";
      5: return "R6";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [3:0] refCrc(input logic [3:0] s, input logic [7:0] b);
    logic [3:0] c = s;
    for (int k = 7; k >= 0; k--) begin
      logic t = c[3] ^ b[k];
      c = {c[2:0], 1'b0};
      if (t) c = c ^ 4'h3;
    end
    return c;
  endfunction

  task automatic step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    inValid = 1'b0; inFrameStart = 1'b0; inMfStart = 1'b0;
    cfgWe = 1'b0; crcResValid = 1'b0;
    @(negedge clk);
    if (outValid !== 1'b0 && !mfBad) begin
      mfBad = 1'b1;
      $display("FAIL %s: outValid during idle actual=%b expected=0", curTag, outValid);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input int ts, input int frm,
                          input logic we, input logic [7:0] wd,
                          input logic rv, input logic ok);
    logic ms, fs;
    logic [7:0] eff, m, cz;
    logic [3:0] acc;
    fs = (ts == 0);
    ms = fs && (frm == 0);
    eff = ms ? mShadow : mActive;
    m = d;
    if (eff[0]) begin
      if (ts != 0 && eff[6]) m = 8'hFF;
      if (ts == 0 && frm % 2 == 1 && eff[4]) m[5] = eff[7];
      if (ts == 0 && (frm == 13 || frm == 15) && eff[5]) m[7] = (frm == 13) ? mE[1] : mE[0];
    end
    cz = m;
    if (ts == 0 && frm % 2 == 0) cz[7] = 1'b0;
    if (eff[0] && ts == 0 && frm % 2 == 0) begin
      if (eff[2:1] == 2'b01) m[7] = 1'b1;
      else if (eff[2:1] == 2'b10) m[7] = mHold[3 - ((frm % 8) / 2)];
    end
    acc = refCrc((ts == 0 && frm % 8 == 0) ? 4'h0 : mAcc, cz);
    if (ts == 31 && frm % 8 == 7) mHold = acc;
    mAcc = acc;
    if (ms) mActive = mShadow;
    if (we) mShadow = wd;
    if (rv) mE = {mE[0], ok};

    inData = d; inValid = 1'b1; inFrameStart = fs; inMfStart = ms;
    cfgWe = we; cfgData = wd; crcResValid = rv; crcResOk = ok;
    @(negedge clk);
    if ((outValid !== 1'b1 || outData !== m) && !mfBad) begin
      mfBad = 1'b1;
      $display("FAIL %s: frm %0d ts %0d actual=%h expected=%h", curTag, frm, ts, outData, m);
    end
  endtask

  task automatic runMf(input string tag, input bit doWr, input logic [7:0] wd,
                       input int wFrm, input int wTs, input bit gaps);
    curTag = tag;
    mfBad = 1'b0;
    for (int f = 0; f < 16; f++) begin
      for (int t = 0; t < 32; t++) begin
        logic we, rv;
        if (gaps && (t % 7 == 3)) idle();
        we = doWr && f == wFrm && t == wTs;
        rv = (f == 2 || f == 9) && t == 3;
        step();
        sendByte(lfsr[7:0], t, f, we, wd, rv, lfsr[9]);
      end
    end
    idle();
    checks++;
    if (mfBad) errors++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0 && outData === 8'h00, "R1", "reset outputs", outData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: write mid multiframe, then check the following multiframe (R3, R10 with gaps)
    for (int i = 0; i < N_CFG; i++) begin
      runMf((i % 3 == 0) ? "R10" : "R3", 1'b1, CFG_TAB[i], 5, 10, (i % 3 == 0));
      runMf(tagOf(i), 1'b0, 8'h00, 0, 0, 1'b0);
    end

    // R5: a second multiframe of recomputed CRC, with a prior submultiframe result in place
    runMf("R5", 1'b1, 8'h05, 7, 31, 1'b0);
    runMf("R5", 1'b0, 8'h00, 0, 0, 1'b1);

    // R3: write on the multiframe-start byte applies one multiframe later
    runMf("R3", 1'b1, 8'h41, 0, 0, 1'b0);
    runMf("R3", 1'b0, 8'h00, 0, 0, 1'b0);

    // R1: outData holds during idle cycles after the last byte
    begin
      logic [7:0] last;
      last = outData;
      idle();
      check(outValid === 1'b0 && outData === last, "R1", "hold during idle", outData, last);
    end

    // R8: timeslot 0 of an alarm multiframe is not filled
    curTag = "R8";
    mfBad = 1'b0;
    sendByte(8'h1B, 0, 0, 1'b0, 8'h00, 1'b0, 1'b0);
    check(outData === 8'h1B && !mfBad, "R8", "timeslot 0 under alarm", outData, 8'h1B);
    sendByte(8'h00, 1, 0, 1'b0, 8'h00, 1'b0, 1'b0);
    check(outData === 8'hFF && !mfBad, "R8", "timeslot 1 under alarm", outData, 8'hFF);

    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule